// File: doc/BRIEF.md
# RV32I Instruction Decode Control Unit

This block turns one 32-bit base-integer instruction word into the control signals a single-cycle datapath needs. It looks at the major opcode and decides whether data memory is read or written and whether the register file is written. It also chooses the two operands an execute stage feeds its ALU: the first is either the rs1 value or the instruction address, and the second is either the rs2 value or the immediate. Alongside these it builds the sign-extended immediate for the I, S, B, U or J format and passes out the three register index fields.

Each memory enable comes from exactly one opcode class. The load class drives the read enable and the store class drives the write enable, so no other opcode touches data memory. Opcodes outside the nine base classes (loads, stores, OP, OP-IMM, LUI, AUIPC, branches, JAL, JALR) clear every enable. The decode logic holds no state. All results leave through one output register stage with a synchronous active-high reset, so a word presented at one rising edge shows its decode after that edge.

Top module: `rvdec_ctrl`

## Requirements
- R1: `mem_rd_o` is 1 only when the opcode bits [6:0] of the word are 0000011 (load). It is 0 for every other opcode.
- R2: `mem_wr_o` is 1 only when the opcode is 0100011 (store). It is 0 for every other opcode.
- R3: `reg_wr_o` is 1 for these opcodes: load, OP 0110011, OP-IMM 0010011, LUI 0110111, AUIPC 0010111, JAL 1101111 and JALR 1100111. It is 0 for store, for branch 1100011 and for any other opcode.
- R4: `op1_pc_o` is 1 (instruction address) for AUIPC, JAL and branch. It is 0 (rs1 value) for every other opcode.
- R5: `op2_imm_o` is 0 (rs2 value) for OP and for unrecognised opcodes. It is 1 (immediate) for the other eight recognised opcodes.
- R6: `imm_o` is built from the word w as follows, with each result sign-extended from w[31]:
  - I format (load, OP-IMM, JALR): w[31:20].
  - S format (store): {w[31:25], w[11:7]}.
  - B format (branch): {w[31], w[7], w[30:25], w[11:8], 0}.
  - U format (LUI, AUIPC): {w[31:12], 12 zero bits}.
  - J format (JAL): {w[31], w[19:12], w[20], w[30:21], 0}.
  - It is 0 for OP and for unrecognised opcodes.
- R7: For every word, `rs1_o` = w[19:15], `rs2_o` = w[24:20] and `rd_o` = w[11:7].
- R8: All outputs are registered. The decode of the word present at a rising edge with `rst` low appears after that edge. A rising edge with `rst` high sets every output to 0.
- R9: Three example words give these memory enables:
  - 0x00A02223 (store word): write enable 1, read enable 0.
  - 0x000022B7 (LUI): both 0.
  - 0x002081B3 (ADD): both 0.
- R10: An unrecognised opcode gives 0 on `mem_rd_o`, `mem_wr_o` and `reg_wr_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_i | input | 32 | Instruction word to decode |
| mem_rd_o | output | 1 | Data-memory read enable |
| mem_wr_o | output | 1 | Data-memory write enable |
| reg_wr_o | output | 1 | Register-file write enable |
| op1_pc_o | output | 1 | ALU operand 1 select: 1 = instruction address, 0 = rs1 value |
| op2_imm_o | output | 1 | ALU operand 2 select: 1 = immediate, 0 = rs2 value |
| imm_o | output | XLEN (32) | Sign-extended immediate |
| rs1_o | output | 5 | Source register 1 index |
| rs2_o | output | 5 | Source register 2 index |
| rd_o | output | 5 | Destination register index |

## Verification
Every output of this block is due exactly one rising edge after the word is presented. Only the single output register lies between `instr_i` and the ports.

The bench changes `instr_i` on a falling edge and lets the next rising edge capture it. It then compares all outputs on the falling edge that follows, before it drives the next word. Reset is checked the same way: `rst` is raised with a load word on the input, and the outputs are expected to be all zero half a cycle after the capturing edge.

The properties use `|=>` to relate the opcode seen at one edge to the outputs at the next edge.

// File: rtl/rvdec_pkg.sv
package rvdec_pkg;
  localparam int ILEN  = 32;
  localparam int OPC_W = 7;
  localparam int REG_W = 5;

  localparam logic [OPC_W-1:0] OPC_LOAD   = 7'b0000011;
  localparam logic [OPC_W-1:0] OPC_STORE  = 7'b0100011;
  localparam logic [OPC_W-1:0] OPC_OP     = 7'b0110011;
  localparam logic [OPC_W-1:0] OPC_OPIMM  = 7'b0010011;
  localparam logic [OPC_W-1:0] OPC_LUI    = 7'b0110111;
  localparam logic [OPC_W-1:0] OPC_AUIPC  = 7'b0010111;
  localparam logic [OPC_W-1:0] OPC_BRANCH = 7'b1100011;
  localparam logic [OPC_W-1:0] OPC_JAL    = 7'b1101111;
  localparam logic [OPC_W-1:0] OPC_JALR   = 7'b1100111;

  typedef enum logic [2:0] {
    FMT_NONE, FMT_I, FMT_S, FMT_B, FMT_U, FMT_J
  } imm_fmt_e;

  typedef struct packed {
    logic     mem_rd;
    logic     mem_wr;
    logic     reg_wr;
    logic     op1_pc;
    logic     op2_imm;
    imm_fmt_e fmt;
  } ctrl_t;
endpackage

// File: rtl/rvdec_class.sv
module rvdec_class
  import rvdec_pkg::*;
(
  input  logic [OPC_W-1:0] opcode,
  output ctrl_t            ctrl
);
  always_comb begin
    ctrl = '0;
    ctrl.fmt = FMT_NONE;
    case (opcode)
      OPC_LOAD: begin
        ctrl.mem_rd = 1'b1; ctrl.reg_wr = 1'b1; ctrl.op2_imm = 1'b1; ctrl.fmt = FMT_I;
      end
      OPC_STORE: begin
        ctrl.mem_wr = 1'b1; ctrl.op2_imm = 1'b1; ctrl.fmt = FMT_S;
      end
      OPC_OP: begin
        ctrl.reg_wr = 1'b1;
      end
      OPC_OPIMM, OPC_JALR: begin
        ctrl.reg_wr = 1'b1; ctrl.op2_imm = 1'b1; ctrl.fmt = FMT_I;
      end
      OPC_LUI: begin
        ctrl.reg_wr = 1'b1; ctrl.op2_imm = 1'b1; ctrl.fmt = FMT_U;
      end
      OPC_AUIPC: begin
        ctrl.reg_wr = 1'b1; ctrl.op1_pc = 1'b1; ctrl.op2_imm = 1'b1; ctrl.fmt = FMT_U;
      end
      OPC_BRANCH: begin
        ctrl.op1_pc = 1'b1; ctrl.op2_imm = 1'b1; ctrl.fmt = FMT_B;
      end
      OPC_JAL: begin
        ctrl.reg_wr = 1'b1; ctrl.op1_pc = 1'b1; ctrl.op2_imm = 1'b1; ctrl.fmt = FMT_J;
      end
      default: ctrl = '0;
    endcase
  end
endmodule

// File: rtl/rvdec_imm.sv
module rvdec_imm
  import rvdec_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [ILEN-1:0] instr,
  input  imm_fmt_e        fmt,
  output logic [XLEN-1:0] imm
);
  logic [ILEN-1:0] raw;

  always_comb begin
    case (fmt)
      FMT_I:   raw = {{20{instr[31]}}, instr[31:20]};
      FMT_S:   raw = {{20{instr[31]}}, instr[31:25], instr[11:7]};
      FMT_B:   raw = {{19{instr[31]}}, instr[31], instr[7], instr[30:25], instr[11:8], 1'b0};
      FMT_U:   raw = {instr[31:12], 12'b0};
      FMT_J:   raw = {{11{instr[31]}}, instr[31], instr[19:12], instr[20], instr[30:21], 1'b0};
      default: raw = '0;
    endcase
  end

  assign imm = XLEN'(signed'(raw));
endmodule

// File: rtl/rvdec_pipereg.sv
module rvdec_pipereg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= d;
  end
endmodule

// File: rtl/rvdec_ctrl.sv
module rvdec_ctrl
  import rvdec_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [31:0]     instr_i,
  output logic            mem_rd_o,
  output logic            mem_wr_o,
  output logic            reg_wr_o,
  output logic            op1_pc_o,
  output logic            op2_imm_o,
  output logic [XLEN-1:0] imm_o,
  output logic [4:0]      rs1_o,
  output logic [4:0]      rs2_o,
  output logic [4:0]      rd_o
);
  localparam int FLAG_W = 5;
  localparam int PW     = FLAG_W + XLEN + 3 * REG_W;

  ctrl_t           ctrl;
  logic [XLEN-1:0] imm_d;
  logic [PW-1:0]   pipe_d, pipe_q;

  rvdec_class u_class (
    .opcode (instr_i[OPC_W-1:0]),
    .ctrl   (ctrl)
  );

  rvdec_imm #(.XLEN(XLEN)) u_imm (
    .instr (instr_i),
    .fmt   (ctrl.fmt),
    .imm   (imm_d)
  );

  assign pipe_d = {ctrl.mem_rd, ctrl.mem_wr, ctrl.reg_wr, ctrl.op1_pc, ctrl.op2_imm,
                   imm_d, instr_i[19:15], instr_i[24:20], instr_i[11:7]};

  rvdec_pipereg #(.W(PW)) u_reg (
    .clk (clk),
    .rst (rst),
    .d   (pipe_d),
    .q   (pipe_q)
  );

  assign {mem_rd_o, mem_wr_o, reg_wr_o, op1_pc_o, op2_imm_o,
          imm_o, rs1_o, rs2_o, rd_o} = pipe_q;
endmodule

// File: rtl/rvdec_ctrl_chk.sv
module rvdec_ctrl_chk
  import rvdec_pkg::*;
#(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rst,
  input logic [31:0]     instr_i,
  input logic            mem_rd_o,
  input logic            mem_wr_o,
  input logic            reg_wr_o,
  input logic            op1_pc_o,
  input logic            op2_imm_o,
  input logic [XLEN-1:0] imm_o,
  input logic [4:0]      rs1_o,
  input logic [4:0]      rs2_o,
  input logic [4:0]      rd_o
);
  logic [OPC_W-1:0] opc;
  logic             known;
  assign opc   = instr_i[OPC_W-1:0];
  assign known = (opc == OPC_LOAD) || (opc == OPC_STORE) || (opc == OPC_OP) ||
                 (opc == OPC_OPIMM) || (opc == OPC_LUI) || (opc == OPC_AUIPC) ||
                 (opc == OPC_BRANCH) || (opc == OPC_JAL) || (opc == OPC_JALR);

  // R1
  load_rd_chk: assert property (@(posedge clk) disable iff (rst)
    (opc == OPC_LOAD) |=> mem_rd_o);
  // R1
  nonload_rd_chk: assert property (@(posedge clk) disable iff (rst)
    (opc != OPC_LOAD) |=> !mem_rd_o);
  // R2
  store_wr_chk: assert property (@(posedge clk) disable iff (rst)
    (opc == OPC_STORE) |=> (mem_wr_o && !reg_wr_o));
  // R2
  nonstore_wr_chk: assert property (@(posedge clk) disable iff (rst)
    (opc != OPC_STORE) |=> !mem_wr_o);
  // R3
  branch_nowr_chk: assert property (@(posedge clk) disable iff (rst)
    (opc == OPC_BRANCH) |=> (!reg_wr_o && op1_pc_o));
  // R10
  unknown_off_chk: assert property (@(posedge clk) disable iff (rst)
    !known |=> (!mem_rd_o && !mem_wr_o && !reg_wr_o));
  // R7
  fields_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (rd_o == $past(instr_i[11:7]) && rs1_o == $past(instr_i[19:15]) &&
              rs2_o == $past(instr_i[24:20])));
  // R8
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (!mem_rd_o && !mem_wr_o && !reg_wr_o && !op1_pc_o && !op2_imm_o &&
             imm_o == '0 && rs1_o == '0 && rs2_o == '0 && rd_o == '0));
  // R1
  excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd_o && mem_wr_o));
endmodule

bind rvdec_ctrl rvdec_ctrl_chk #(.XLEN(XLEN)) u_chk (.*);

// File: tb/rvdec_ctrl_tb.sv
module rvdec_ctrl_tb;
  localparam int XLEN = 32;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [31:0]     instr_i = 32'h0;
  logic            mem_rd_o, mem_wr_o, reg_wr_o, op1_pc_o, op2_imm_o;
  logic [XLEN-1:0] imm_o;
  logic [4:0]      rs1_o, rs2_o, rd_o;

  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  rvdec_ctrl #(.XLEN(XLEN)) u_dut (.*);

  // expected {rd, wr, regwr, op1pc, op2imm}
  function automatic logic [4:0] exp_flags(input logic [6:0] o);
    case (o)
      7'b0000011: return 5'b10101;
      7'b0100011: return 5'b01001;
      7'b0110011: return 5'b00100;
      7'b0010011: return 5'b00101;
      7'b1100111: return 5'b00101;
      7'b0110111: return 5'b00101;
      7'b0010111: return 5'b00111;
      7'b1100011: return 5'b00011;
      7'b1101111: return 5'b00111;
      default:    return 5'b00000;
    endcase
  endfunction

  function automatic logic [31:0] exp_imm(input logic [31:0] w);
    logic [31:0] s;
    s = {32{w[31]}};
    case (w[6:0])
      7'b0000011, 7'b0010011, 7'b1100111: return {s[31:12], w[31:20]};
      7'b0100011: return {s[31:12], w[31:25], w[11:7]};
      7'b1100011: return {s[31:13], w[31], w[7], w[30:25], w[11:8], 1'b0};
      7'b0110111, 7'b0010111: return {w[31:12], 12'h000};
      7'b1101111: return {s[31:21], w[31], w[19:12], w[20], w[30:21], 1'b0};
      default: return 32'h0;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%h exp=%h instr=%h", tag, act, exp, instr_i);
    end
  endtask

  task automatic apply(input logic [31:0] w);
    logic [4:0] f;
    @(negedge clk);
    instr_i = w;
    @(negedge clk);
    f = exp_flags(w[6:0]);
    chk("R1 mem_rd", 32'(mem_rd_o), 32'(f[4]));
    chk("R2 mem_wr", 32'(mem_wr_o), 32'(f[3]));
    chk("R3 reg_wr", 32'(reg_wr_o), 32'(f[2]));
    chk("R4 op1_pc", 32'(op1_pc_o), 32'(f[1]));
    chk("R5 op2_imm", 32'(op2_imm_o), 32'(f[0]));
    chk("R6 imm", imm_o, exp_imm(w));
    chk("R7 rs1", 32'(rs1_o), 32'(w[19:15]));
    chk("R7 rs2", 32'(rs2_o), 32'(w[24:20]));
    chk("R7 rd", 32'(rd_o), 32'(w[11:7]));
  endtask

  initial begin
    automatic logic [6:0] opcs [9] = '{7'b0000011, 7'b0100011, 7'b0110011, 7'b0010011,
      7'b0110111, 7'b0010111, 7'b1100011, 7'b1101111, 7'b1100111};
    automatic int unsigned seed = 32'd12345;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    chk("R8 reset flags", 32'({mem_rd_o, mem_wr_o, reg_wr_o, op1_pc_o, op2_imm_o}), 32'h0);
    chk("R8 reset imm", imm_o, 32'h0);
    chk("R8 reset idx", 32'({rs1_o, rs2_o, rd_o}), 32'h0);
    rst = 1'b0;

    // R9 directed words
    apply(32'h00A02223);
    chk("R9 sw wr", 32'(mem_wr_o), 32'd1);
    chk("R9 sw rd", 32'(mem_rd_o), 32'd0);
    apply(32'h000022B7);
    chk("R9 lui enables", 32'({mem_rd_o, mem_wr_o}), 32'd0);
    apply(32'h002081B3);
    chk("R9 add enables", 32'({mem_rd_o, mem_wr_o}), 32'd0);

    // R6 sign corners and R10 unknown opcodes
    apply(32'hFFF00013);
    apply(32'h80000063);
    apply(32'hFFFFF0EF);
    apply(32'h7FFFF037);
    apply(32'hFE000FA3);
    apply(32'h0000000F);
    chk("R10 fence off", 32'({mem_rd_o, mem_wr_o, reg_wr_o}), 32'd0);
    apply(32'hFFFFFF73);
    chk("R10 system off", 32'({mem_rd_o, mem_wr_o, reg_wr_o}), 32'd0);
    apply(32'h00000003 ^ 32'h1);

    for (int i = 0; i < 600; i++) begin
      automatic logic [31:0] w = $urandom();
      if ((i % 4) != 0) w[6:0] = opcs[$urandom_range(8, 0)];
      apply(w);
    end

    // R8 reset taken mid-stream clears outputs
    @(negedge clk);
    instr_i = 32'hFFF0A083;
    rst = 1'b1;
    @(negedge clk);
    chk("R8 mid reset flags", 32'({mem_rd_o, mem_wr_o, reg_wr_o, op1_pc_o, op2_imm_o}), 32'h0);
    chk("R8 mid reset imm", imm_o, 32'h0);
    rst = 1'b0;
    apply(32'hFFF0A083);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #400000;
    checks++;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule